// File: doc/BRIEF.md
# Snapshot-Coherent Byte-Read Timer Counter

This block holds a 16-bit free-running count that advances by one on every cycle in which the prescaled tick enable is high. It wraps from all ones to zero and marks the wrap with a one-cycle overflow strobe. The full count value is also sent straight out for comparators elsewhere on the chip.

A byte-wide bus reads the count as two bytes: the upper byte at offset 0x0E and the lower byte at offset 0x0F. Software reads the upper byte first. That read stores the lower byte of the same count in a snapshot register. If the lower byte is read in the bus cycle right after, it comes from the snapshot. The two bytes then describe one count value, even when a tick carries between them. A lower-byte read at any other time returns the live lower byte.

In normal operation the count cannot be written. When the special-mode enable is high, a bus write to either offset loads that byte of the count.

Top module: `tmr_count_top`

## Requirements
- R1: On reset the count is 0x0000, the overflow strobe is low and the read data is zero; any pending snapshot is discarded.
- R2: The count increases by one after each clock edge at which the tick enable is high and no load happens.
- R3: A tick that finds the count at 0xFFFF takes it to 0x0000, and the overflow strobe is high for exactly the one cycle after that edge.
- R4: A read strobe at offset 0x0E returns bits 15:8 of the count in the same cycle.
- R5: A read strobe at offset 0x0F in the cycle right after a 0x0E read returns bits 7:0 of the count as it was during the 0x0E read.
- R6: A read strobe at offset 0x0F at any other time returns the live bits 7:0.
- R7: With the special-mode enable low, a write strobe does not change the count, and without a tick the count holds its value.
- R8: With the special-mode enable high, a write at 0x0E loads bits 15:8 and a write at 0x0F loads bits 7:0 from the write data. The other byte keeps its value and no increment happens in that cycle.
- R9: The read data is zero when the read strobe is low or the offset is neither 0x0E nor 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled count enable |
| bus_addr | input | 8 | Register offset |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| test_mode | input | 1 | Special-mode write enable |
| rd_data | output | 8 | Read byte, valid in the strobe cycle |
| cnt_val | output | 16 | Full count for compare logic |
| ovf_pulse | output | 1 | One-cycle wrap strobe |

## Verification
On every cycle the assertions check that the count steps, holds and loads bytes correctly, that the overflow strobe appears only with a zero count, that the snapshot equals the lower byte seen during the upper-byte read, and that the read data is zero when the read strobe is idle. Some behaviour shows only in the bench's scenarios. One case is a read pair across a carry, where the snapshot differs from the live byte. Another is a lower-byte read one cycle too late, which must return the live byte. The bench also covers a write that is ignored outside special mode, and a reset in the middle of a run.

// File: rtl/tmr_count_pkg.sv
package tmr_count_pkg;

    localparam int BYTE_W = 8;
    localparam int NBYTES = 2;
    localparam int CNT_W  = BYTE_W * NBYTES;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2
    } byte_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        byte_sel_e         sel;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    function automatic byte_sel_e decode_sel(input logic [7:0] addr,
                                             input logic [7:0] hi_ofs,
                                             input logic [7:0] lo_ofs);
        if (addr == hi_ofs)      return SEL_HI;
        else if (addr == lo_ofs) return SEL_LO;
        else                     return SEL_NONE;
    endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_count_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] HI_OFS = 8'h0E,
    parameter logic [ADDR_W-1:0] LO_OFS = 8'h0F
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              test_mode,
    output bus_req_t          req,
    output logic [NBYTES-1:0] ld_mask
);
    localparam logic [7:0] HI8 = 8'(HI_OFS);
    localparam logic [7:0] LO8 = 8'(LO_OFS);

    always_comb begin
        req.rd    = rd_stb;
        req.wr    = wr_stb;
        req.sel   = decode_sel(8'(bus_addr), HI8, LO8);
        req.wdata = wr_data;
    end

    always_comb begin
        ld_mask    = '0;
        ld_mask[1] = wr_stb && test_mode && (req.sel == SEL_HI);
        ld_mask[0] = wr_stb && test_mode && (req.sel == SEL_LO);
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_count_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [NBYTES-1:0] ld_mask,
    input  logic [BYTE_W-1:0] ld_byte,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;
    logic             any_ld;

    assign any_ld = |ld_mask;
    assign wrap   = tick_en && !any_ld && (cnt == '1);

    always_comb begin
        cnt_nxt = cnt;
        if (any_ld) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (ld_mask[b]) cnt_nxt[b*BYTE_W +: BYTE_W] = ld_byte;
            end
        end else if (tick_en) begin
            cnt_nxt = cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            ovf <= wrap;
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !any_ld) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !any_ld) |=> $stable(cnt));

    // R3
    ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cnt == '0));

    // R3
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_lane
            // R8
            lane_load_chk: assert property (@(posedge clk) disable iff (rst)
                ld_mask[g] |=> (cnt[g*BYTE_W +: BYTE_W] == $past(ld_byte)));
        end
    endgenerate
endmodule

// File: rtl/tmr_snap_buf.sv
module tmr_snap_buf
    import tmr_count_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_rd,
    input  logic [BYTE_W-1:0] lo_live,
    output logic              snap_v,
    output logic [BYTE_W-1:0] snap_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_v    <= 1'b0;
            snap_byte <= '0;
        end else begin
            snap_v <= hi_rd;
            if (hi_rd) snap_byte <= lo_live;
        end
    end

    // R5
    snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
        hi_rd |=> (snap_v && snap_byte == $past(lo_live)));

    // R6
    snap_expire_chk: assert property (@(posedge clk) disable iff (rst)
        !hi_rd |=> !snap_v);
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_count_pkg::*;
(
    input  bus_req_t          req,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              snap_v,
    input  logic [BYTE_W-1:0] snap_byte,
    output logic [BYTE_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (req.rd) begin
            unique case (req.sel)
                SEL_HI:  rd_data = cnt[CNT_W-1 -: BYTE_W];
                SEL_LO:  rd_data = snap_v ? snap_byte : cnt[BYTE_W-1:0];
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_count_top.sv
module tmr_count_top
    import tmr_count_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] HI_OFS = 8'h0E,
    parameter logic [ADDR_W-1:0] LO_OFS = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              test_mode,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              ovf_pulse
);
    bus_req_t          req;
    logic [NBYTES-1:0] ld_mask;
    logic              snap_v;
    logic [BYTE_W-1:0] snap_byte;
    logic              hi_rd;

    tmr_addr_dec #(.ADDR_W(ADDR_W), .HI_OFS(HI_OFS), .LO_OFS(LO_OFS)) dec_i (
        .bus_addr (bus_addr),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .test_mode(test_mode),
        .req      (req),
        .ld_mask  (ld_mask)
    );

    tmr_count_core core_i (
        .clk    (clk),
        .rst    (rst),
        .tick_en(tick_en),
        .ld_mask(ld_mask),
        .ld_byte(req.wdata),
        .cnt    (cnt_val),
        .ovf    (ovf_pulse)
    );

    assign hi_rd = req.rd && (req.sel == SEL_HI);

    tmr_snap_buf snap_i (
        .clk      (clk),
        .rst      (rst),
        .hi_rd    (hi_rd),
        .lo_live  (cnt_val[BYTE_W-1:0]),
        .snap_v   (snap_v),
        .snap_byte(snap_byte)
    );

    tmr_rd_mux mux_i (
        .req      (req),
        .cnt      (cnt_val),
        .snap_v   (snap_v),
        .snap_byte(snap_byte),
        .rd_data  (rd_data)
    );

    // R9
    idle_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |-> (rd_data == '0));

    // R7
    locked_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !test_mode && !tick_en) |=> $stable(cnt_val));
endmodule

// File: tb/tmr_count_top_tb_top.sv
module tmr_count_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en, rd_stb, wr_stb, test_mode;
    logic [7:0]  bus_addr, wr_data;
    logic [7:0]  rd_data;
    logic [15:0] cnt_val;
    logic        ovf_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tmr_count_top dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
        .test_mode(test_mode), .rd_data(rd_data), .cnt_val(cnt_val),
        .ovf_pulse(ovf_pulse)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic        tick;
        logic        rd;
        logic        wr;
        logic        tm;
        logic [7:0]  addr;
        logic [7:0]  wd;
        logic [7:0]  exp_rd;
        logic [15:0] exp_cnt;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{"R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h0001},
        '{"R8", 1'b1, 1'b0, 1'b1, 1'b1, 8'h0E, 8'h12, 8'h00, 16'h1201},
        '{"R8", 1'b0, 1'b0, 1'b1, 1'b1, 8'h0F, 8'hFE, 8'h00, 16'h12FE},
        '{"R4", 1'b1, 1'b1, 1'b0, 1'b0, 8'h0E, 8'h00, 8'h12, 16'h12FF},
        '{"R5", 1'b1, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h00, 8'hFE, 16'h1300},
        '{"R6", 1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h00, 8'h00, 16'h1300},
        '{"R7", 1'b0, 1'b0, 1'b1, 1'b0, 8'h0E, 8'hAA, 8'h00, 16'h1300},
        '{"R4", 1'b1, 1'b1, 1'b0, 1'b0, 8'h0E, 8'h00, 8'h13, 16'h1301},
        '{"R2", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 16'h1302},
        '{"R6", 1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h00, 8'h02, 16'h1302},
        '{"R9", 1'b0, 1'b1, 1'b0, 1'b0, 8'h05, 8'h00, 8'h00, 16'h1302}
    };

    task automatic report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic t, input logic r, input logic w,
                         input logic m, input logic [7:0] a, input logic [7:0] d);
        tick_en = t; rd_stb = r; wr_stb = w; test_mode = m; bus_addr = a; wr_data = d;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 8'h00, 8'h00);
        repeat (2) @(posedge clk);
        #1;
        chk("R1 count", cnt_val, 16'h0000);
        chk("R1 ovf", {15'd0, ovf_pulse}, 16'h0000);
        chk("R1 rd", {8'd0, rd_data}, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].tick, TBL[i].rd, TBL[i].wr, TBL[i].tm, TBL[i].addr, TBL[i].wd);
            #1;
            chk({string'(TBL[i].tag), " rd"}, {8'd0, rd_data}, {8'd0, TBL[i].exp_rd});
            @(posedge clk);
            #1;
            chk({string'(TBL[i].tag), " cnt"}, cnt_val, TBL[i].exp_cnt);
            @(negedge clk);
        end

        // R3 wrap and overflow strobe
        drive(0, 0, 1, 1, 8'h0E, 8'hFF);
        @(posedge clk); @(negedge clk);
        drive(0, 0, 1, 1, 8'h0F, 8'hFF);
        @(posedge clk); #1;
        chk("R8 full load", cnt_val, 16'hFFFF);
        chk("R3 no early ovf", {15'd0, ovf_pulse}, 16'h0000);
        @(negedge clk);
        drive(1, 0, 0, 0, 8'h00, 8'h00);
        @(posedge clk); #1;
        chk("R3 wrap count", cnt_val, 16'h0000);
        chk("R3 ovf high", {15'd0, ovf_pulse}, 16'h0001);
        @(negedge clk);
        drive(0, 0, 0, 0, 8'h00, 8'h00);
        @(posedge clk); #1;
        chk("R3 ovf one cycle", {15'd0, ovf_pulse}, 16'h0000);

        // R1 mid-run reset discards snapshot
        @(negedge clk);
        drive(1, 1, 0, 0, 8'h0E, 8'h00);
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0, 8'h00, 8'h00);
        @(posedge clk); #1;
        chk("R1 mid reset count", cnt_val, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        drive(0, 1, 0, 0, 8'h0F, 8'h00);
        #1;
        chk("R1 snapshot cleared", {8'd0, rd_data}, 16'h0000);
        @(negedge clk);
        drive(0, 0, 0, 0, 8'h00, 8'h00);
        @(negedge clk);
        report();
    end
endmodule